// File: doc/BRIEF.md
# Tag Manchester Readout Sequencer

This block is the digital core of a passively powered, read-only tag. It runs only on the clock recovered from the RF carrier. It holds a fixed 128-bit pattern, organised as 16 bytes of 8 bits, and sends it out serially in a loop for as long as power-on reset stays released. Each bit is Manchester coded onto `mod_o`, which drives the switch that loads the coil. No command or handshake starts the readout. Releasing reset is enough.

A strap input selects the bit period: 64 carrier cycles, or 32 in short mode. The strap is latched once, when the core arms after reset. A carrier-cycle prescaler marks each bit period and its midpoint. Byte and bit address counters walk the memory. A one-cycle `bit_start_o` strobe marks the start of each bit period so it can be observed. The memory contents come from the `ROM_INIT` parameter. Byte `b` occupies `ROM_INIT[8*b+7 : 8*b]`.

Top module: `tag_readout_core`

## Requirements
- R1: While `rst_ni` is low, `mod_o` and `bit_start_o` are low, and the prescaler and address counters are cleared.
- R2: The first rising clock edge after reset release arms the core. `bit_start_o` is high during the cycle that follows, and the period of bit 0 begins in that same cycle.
- R3: With the latched strap at 0, every bit period lasts 64 carrier cycles. `bit_start_o` is high in the first cycle of each period only.
- R4: With the latched strap at 1, every bit period lasts 32 carrier cycles, with the same strobe behaviour.
- R5: A 1 is sent as `mod_o` high for the first half of the period and low for the second half. A 0 is sent as low then high. The only change inside a period falls at carrier count 32, or 16 in short mode.
- R6: Bytes are sent from address 0 up to address 15. Within a byte, bit 7 goes first. Byte `b` is `ROM_INIT[8*b+7 : 8*b]`.
- R7: After the 128th bit, readout returns to bit 0 with no gap and repeats without end.
- R8: Asserting reset in the middle of a bit forces `mod_o` low at once. After release, readout restarts from bit 0 with a fresh prescaler.
- R9: `short_bit_i` is sampled only on the arming edge. Changes to it while the core runs do not affect the period length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock recovered from the carrier |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| short_bit_i | input | 1 | Period strap: 0 gives 64 cycles per bit, 1 gives 32 cycles per bit |
| mod_o | output | 1 | Manchester-coded coil load control; high means loaded |
| bit_start_o | output | 1 | One-cycle strobe at the start of each bit period |

## Verification
The memory pattern mixes runs of equal bits, alternating bits and asymmetric bytes. A wrong bit order within a byte, a wrong byte order or swapped Manchester phases therefore change the decoded stream. The stream is decoded over more than two full wraps in each strap mode. This separates a correct wrap from a stall or skip at the boundary, and shows that the 32-cycle and 64-cycle periods each place their midpoint correctly. The strap is toggled in the middle of a run to show that the latched period holds. A reset is applied in the middle of a bit to show the output dropping at once and the readout restarting from bit 0.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef enum logic {
    PER_LONG  = 1'b0,
    PER_SHORT = 1'b1
  } period_e;
endpackage

// File: rtl/tag_bit_timer.sv
module tag_bit_timer #(
  parameter int LONG_CYC  = 64,
  parameter int SHORT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  tag_pkg::period_e per_i,
  output logic bit_start_o,
  output logic late_half_o,
  output logic bit_end_o
);
  localparam int CW = $clog2(LONG_CYC);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_HALF  = CW'(LONG_CYC / 2);
  localparam logic [CW-1:0] SHORT_HALF = CW'(SHORT_CYC / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last, half;

  always_comb begin
    if (per_i == tag_pkg::PER_SHORT) begin
      last = SHORT_LAST;
      half = SHORT_HALF;
    end else begin
      last = LONG_LAST;
      half = LONG_HALF;
    end
  end

  assign bit_end_o   = run_i && (cnt_q == last);
  assign bit_start_o = run_i && (cnt_q == '0);
  assign late_half_o = (cnt_q >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tag_addr_ctr.sv
module tag_addr_ctr #(
  parameter int NUM_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic [$clog2(NUM_BYTES)-1:0] byte_o,
  output logic [$clog2(BYTE_W)-1:0]    slot_o
);
  localparam int BAW = $clog2(NUM_BYTES);
  localparam int SW  = $clog2(BYTE_W);
  localparam logic [BAW-1:0] BYTE_LAST = BAW'(NUM_BYTES - 1);
  localparam logic [SW-1:0]  SLOT_LAST = SW'(BYTE_W - 1);

  logic [BAW-1:0] byte_q;
  logic [SW-1:0]  slot_q;
  logic           slot_wrap;

  assign slot_wrap = (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      byte_q <= '0;
    end else if (step_i) begin
      slot_q <= slot_wrap ? '0 : slot_q + 1'b1;
      if (slot_wrap) byte_q <= (byte_q == BYTE_LAST) ? '0 : byte_q + 1'b1;
    end
  end

  assign byte_o = byte_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/tag_rom_sel.sv
module tag_rom_sel #(
  parameter int NUM_BYTES = 16,
  parameter int BYTE_W    = 8,
  parameter logic [NUM_BYTES*BYTE_W-1:0] ROM_INIT = '0
) (
  input  logic [$clog2(NUM_BYTES)-1:0] byte_i,
  input  logic [$clog2(BYTE_W)-1:0]    slot_i,
  output logic                         data_o
);
  localparam int TOTAL = NUM_BYTES * BYTE_W;
  localparam int IW    = $clog2(TOTAL);

  // send-order view: slot 0 of each byte is its MSB
  logic [TOTAL-1:0] seq;
  logic [IW-1:0]    idx;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    for (genvar k = 0; k < BYTE_W; k++) begin : g_slot
      assign seq[b*BYTE_W + k] = ROM_INIT[b*BYTE_W + BYTE_W - 1 - k];
    end
  end

  assign idx    = IW'(byte_i) * IW'(BYTE_W) + IW'(slot_i);
  assign data_o = seq[idx];
endmodule

// File: rtl/tag_manch_enc.sv
module tag_manch_enc (
  input  logic en_i,
  input  logic data_i,
  input  logic late_half_i,
  output logic mod_o
);
  // 1 -> high then low, 0 -> low then high
  assign mod_o = en_i & (data_i ^ late_half_i);
endmodule

// File: rtl/tag_readout_core.sv
module tag_readout_core #(
  parameter int NUM_BYTES = 16,
  parameter int BYTE_W    = 8,
  parameter int LONG_CYC  = 64,
  parameter int SHORT_CYC = 32,
  parameter logic [NUM_BYTES*BYTE_W-1:0] ROM_INIT = 128'hC3A5_0F96_7E18_E7DB_2469_B1D0_5AF0_8C3E
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic short_bit_i,
  output logic mod_o,
  output logic bit_start_o
);
  localparam int BAW = $clog2(NUM_BYTES);
  localparam int SW  = $clog2(BYTE_W);

  logic             run_q;
  tag_pkg::period_e mode_q;
  logic             late_half, bit_end, cur_bit;
  logic [BAW-1:0]   byte_idx;
  logic [SW-1:0]    slot_idx;

  // arm on first edge after reset; strap is latched only then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= tag_pkg::PER_LONG;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      mode_q <= short_bit_i ? tag_pkg::PER_SHORT : tag_pkg::PER_LONG;
    end
  end

  tag_bit_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .per_i      (mode_q),
    .bit_start_o(bit_start_o),
    .late_half_o(late_half),
    .bit_end_o  (bit_end)
  );

  tag_addr_ctr #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(bit_end),
    .byte_o(byte_idx),
    .slot_o(slot_idx)
  );

  tag_rom_sel #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .ROM_INIT(ROM_INIT)) u_rom (
    .byte_i(byte_idx),
    .slot_i(slot_idx),
    .data_o(cur_bit)
  );

  tag_manch_enc u_enc (
    .en_i       (run_q),
    .data_i     (cur_bit),
    .late_half_i(late_half),
    .mod_o      (mod_o)
  );
endmodule

// File: rtl/tag_readout_core_chk.sv
module tag_readout_core_chk #(
  parameter int LONG_CYC  = 64,
  parameter int SHORT_CYC = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mod_o,
  input logic             bit_start_o,
  input logic             run_i,
  input tag_pkg::period_e mode_i
);
  localparam int GW = $clog2(LONG_CYC) + 2;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic [GW-1:0] per, half;

  assign per  = (mode_i == tag_pkg::PER_SHORT) ? GW'(SHORT_CYC) : GW'(LONG_CYC);
  assign half = per >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (bit_start_o) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!mod_o && !bit_start_o);
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |=> !bit_start_o);

  p_period_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_start_o && seen_q) |-> (gap_q == per));

  p_mid_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !bit_start_o && gap_q == half) |-> (mod_o != $past(mod_o)));

  p_flat_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !bit_start_o && gap_q != half) |-> $stable(mod_o));

  p_strap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(mode_i));
endmodule

bind tag_readout_core tag_readout_core_chk #(
  .LONG_CYC (LONG_CYC),
  .SHORT_CYC(SHORT_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mod_o      (mod_o),
  .bit_start_o(bit_start_o),
  .run_i      (run_q),
  .mode_i     (mode_q)
);

// File: tb/tag_readout_core_test.sv
module tag_readout_core_test;
  localparam logic [127:0] ROM = 128'h5AC3_0F96_E71B_8D24_FF00_3CA5_6B19_D2E7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic mod, bs;

  always #5 clk = ~clk;

  tag_readout_core #(.ROM_INIT(ROM)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .short_bit_i(strap),
    .mod_o      (mod),
    .bit_start_o(bs)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit m_run = 0;
  int m_cnt = 0, m_idx = 0, m_bits = 0, m_short = 0;
  bit in_r9 = 0, second_run = 0, first_half = 0;
  bit decoded[$];

  function automatic int per_of(int s);
    return s ? 32 : 64;
  endfunction

  // byte b sits at ROM[8b+7:8b], MSB leaves first
  function automatic bit rom_bit(int idx);
    return ROM[(idx / 8) * 8 + 7 - (idx % 8)];
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_idx = 0; m_bits = 0;
    end else if (!m_run) begin
      m_run = 1; m_short = strap; m_cnt = 0; m_idx = 0; m_bits = 0;
    end else if (m_cnt == per_of(m_short) - 1) begin
      m_cnt = 0; m_idx = (m_idx + 1) % 128; m_bits++;
    end else begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    int  per;
    bit  exp_bs, exp_mod;
    string tag;
    per     = per_of(m_short);
    exp_bs  = m_run && (m_cnt == 0);
    exp_mod = m_run && (rom_bit(m_idx) ? (m_cnt < per / 2) : (m_cnt >= per / 2));
    if (!rst_n) tag = "R1";
    else if (in_r9) tag = "R9";
    else if (m_bits >= 128) tag = "R7";
    else if (second_run && m_bits < 8) tag = "R8";
    else tag = "R5";
    chk(mod == exp_mod, tag, "mod_o", mod, exp_mod);
    if (!rst_n) tag = "R1";
    else if (in_r9) tag = "R9";
    else tag = m_short ? "R4" : "R3";
    chk(bs == exp_bs, tag, "bit_start_o", bs, exp_bs);
    // decode each bit at its quarter points
    if (m_run && rst_n) begin
      if (m_cnt == per / 4) first_half = mod;
      if (m_cnt == 3 * per / 4) begin
        tag = (m_bits >= 128) ? "R7" : "R6";
        chk(mod == !first_half, tag, "manchester halves differ", mod, !first_half);
        chk(first_half == rom_bit(m_idx), tag, "decoded bit", first_half, rom_bit(m_idx));
        decoded.push_back(first_half);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic drive_step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic release_and_arm(bit exp_mod0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(bs == 1'b0, "R2", "strobe before arming", bs, 0);
    @(negedge clk);
    chk(bs == 1'b1, "R2", "strobe after arming", bs, 1);
    chk(mod == exp_mod0, "R2", "first half of bit 0", mod, exp_mod0);
  endtask

  task automatic check_stream(string tag);
    for (int i = 0; i < decoded.size(); i++) begin
      if (decoded[i] != rom_bit(i % 128)) begin
        chk(1'b0, tag, "stream bit", decoded[i], rom_bit(i % 128));
        return;
      end
    end
    chk(decoded.size() >= 256, tag, "decoded bits over two wraps", decoded.size(), 256);
  endtask

  initial begin
    drive_step(4);
    chk(mod == 1'b0 && bs == 1'b0, "R1", "outputs in reset", {mod, bs}, 0);
    release_and_arm(rom_bit(0));
    drive_step(3000);
    strap = 1'b1; in_r9 = 1'b1;
    drive_step(4000);
    strap = 1'b0; in_r9 = 1'b0;
    while (m_bits < 259) drive_step(1);
    check_stream("R7");
    // reset in mid-bit, switch to short periods
    drive_step(20);
    rst_n = 1'b0;
    strap = 1'b1;
    @(negedge clk);
    chk(mod == 1'b0 && bs == 1'b0, "R8", "outputs on mid-bit reset", {mod, bs}, 0);
    decoded.delete();
    second_run = 1'b1;
    drive_step(3);
    release_and_arm(rom_bit(0));
    drive_step(1500);
    strap = 1'b0; in_r9 = 1'b1;
    drive_step(2500);
    strap = 1'b1; in_r9 = 1'b0;
    while (m_bits < 259) drive_step(1);
    check_stream("R4");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule